// File: doc/BRIEF.md
# T1/E1 Receive Data Link Extractor

This block sits on the receive line clock, after line decoding. It copies every received bit, framing bits included, to a serial data-link output with one register of delay and no slip buffering. An external framer supplies three signals: a start-of-frame pulse, a per-frame tag and an alignment-valid flag. From these the block tracks the bit position inside the frame. It marks the bits that carry the embedded data link and raises a strobe for each marked bit, so a downstream device can clock those bits in.

In T1 mode the marked bit is the framing bit of the frames the framer tags as odd-numbered. With a 193-bit frame this gives a 4 kHz strobe. In E1 mode the marked bits are any of the five national bits Sa4..Sa8 in timeslot 0 of frames tagged as non-frame-alignment frames. Each selected national bit adds 4 kHz, so the strobe runs at 4 to 20 kHz. The strobe can be a gated copy of the line clock, with its rising edge in the middle of the bit, or a one-bit-wide enable. In T1 an inverse-mux setting replaces the strobe with the raw line clock. The marked bits are also packed MSB-first into a byte for a host, and a ready pulse is raised for each full byte.

Top module: `rx_dlink_extract`

## Requirements
- R1: With rst_n low at a rising line_clk edge, dl_data, dl_byte and dl_byte_rdy become 0 and no bit is marked, so dl_strobe is 0 in enable mode.
- R2: Every bit on rx_data appears on dl_data one line_clk cycle after the edge that samples it, whether it is marked or not.
- R3: In T1 mode (cfg_e1=0), only bit position 0 is marked, and only in frames whose frm_tag was 1 at frm_sof. Bit position 0 is the framing bit, the bit sampled with frm_sof=1. There is exactly one mark per such frame.
- R4: In E1 mode (cfg_e1=1), only frames tagged 1 are marked. In those frames, bit positions 3 to 7 (Sa4..Sa8) are marked when cfg_sa_mask bit (position-3) is 1, so bit 0 selects Sa4 and bit 4 selects Sa8. Frames tagged 0 are never marked.
- R5: With cfg_strobe_en=1, dl_strobe is high for exactly the line_clk period in which dl_data carries a marked bit, over both clock phases.
- R6: With cfg_strobe_en=0, dl_strobe is high only in the low phase of line_clk during a marked bit, so its rising edge falls on the falling line_clk edge in the middle of that bit.
- R7: With cfg_imux=1 and cfg_e1=0, dl_strobe equals line_clk. In E1 mode cfg_imux has no effect.
- R8: While frm_lock=0 no bit is marked and no byte is completed. Loss of lock clears the collected-bit count, so the next byte starts with the first mark after lock returns.
- R9: Marked bits shift MSB-first into dl_byte. dl_byte_rdy pulses for one cycle together with the eighth marked bit, and dl_byte then holds the full byte.
- R10: frm_sof restarts the bit position at 0. Without frm_sof the position wraps after 193 bits (T1) or 256 bits (E1), and the last tag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Decoded received bit |
| frm_sof | input | 1 | High on the first bit of each frame |
| frm_tag | input | 1 | Sampled with frm_sof: odd frame (T1) or non-frame-alignment frame (E1) |
| frm_lock | input | 1 | Framer reports frame alignment |
| cfg_e1 | input | 1 | 0 = T1, 1 = E1 |
| cfg_strobe_en | input | 1 | 1 = enable strobe, 0 = gated clock strobe |
| cfg_imux | input | 1 | T1 inverse-mux: strobe is the line clock |
| cfg_sa_mask | input | 5 | E1 national bit select, bit 0 = Sa4 .. bit 4 = Sa8 |
| dl_data | output | 1 | Received stream, every bit |
| dl_strobe | output | 1 | Data-link clock or enable |
| dl_byte | output | 8 | Collected data-link bits, MSB first |
| dl_byte_rdy | output | 1 | One-cycle pulse when a byte completes |

## Verification
The hardest case to reach from the ports is a loss of alignment in the middle of a byte. Checking it needs partial collection, then an unlocked frame, then a recount that lands the ready pulse on exactly the eighth new mark. The stimulus reaches it by selecting three national bits for one frame, dropping frm_lock for a whole frame and then relocking. A bench-side position and byte model predicts every bit, strobe phase and ready pulse. Free-running wrap with no frame pulses and the T1 inverse-mux clock are driven directly and observed in both clock phases.

// File: rtl/dlx_pkg.sv
// Shared constants for the receive data link extractor.
// Assumes one received bit per line clock cycle.
package dlx_pkg;
    localparam int unsigned T1_BITS   = 193;  // bits per T1 frame
    localparam int unsigned E1_BITS   = 256;  // bits per E1 frame
    localparam int unsigned SA_LO     = 3;    // position of Sa4 in timeslot 0
    localparam int unsigned SA_N      = 5;    // Sa4..Sa8
    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic {
        LINE_T1 = 1'b0,
        LINE_E1 = 1'b1
    } line_mode_e;
endpackage

// File: rtl/dlx_frame_pos.sv
// Bit position tracker. Restarts at 0 on the framer's start-of-frame pulse
// and free-runs with wrap at the frame length of the current mode.
// The frame tag is captured with the start-of-frame pulse.
// Assumes the framer gives frm_sof on bit 0 of the frame.
module dlx_frame_pos #(
    parameter int unsigned T1_FRAME = dlx_pkg::T1_BITS,
    parameter int unsigned E1_FRAME = dlx_pkg::E1_BITS,
    parameter int unsigned POS_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dlx_pkg::line_mode_e mode,
    input  logic             sof,
    input  logic             tag_in,
    output logic [POS_W-1:0] pos,
    output logic             tag
);
    localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_FRAME - 1);
    localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_FRAME - 1);

    logic [POS_W-1:0] pos_q;
    logic             tag_q;
    logic [POS_W-1:0] last;

    // Select the final position of a frame for the current mode.
    always_comb last = (mode == dlx_pkg::LINE_E1) ? E1_LAST : T1_LAST;

    // Position of the bit on the input in this cycle.
    always_comb begin
        if (sof)
            pos = '0;
        else if (pos_q >= last)
            pos = '0;
        else
            pos = pos_q + 1'b1;
    end

    // Tag in force for the bit on the input in this cycle.
    always_comb tag = sof ? tag_in : tag_q;

    // Hold position and tag for the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            tag_q <= 1'b0;
        end else begin
            pos_q <= pos;
            tag_q <= tag;
        end
    end

    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (pos_q == '0)); // R10
endmodule

// File: rtl/dlx_bit_select.sv
// Decides whether the current bit belongs to the data link.
// T1: the framing bit of tagged frames. E1: masked Sa bits of tagged frames.
// Purely combinational. Assumes the position comes from dlx_frame_pos.
module dlx_bit_select #(
    parameter int unsigned SA_FIRST = dlx_pkg::SA_LO,
    parameter int unsigned SA_COUNT = dlx_pkg::SA_N,
    parameter int unsigned POS_W    = 8
) (
    input  dlx_pkg::line_mode_e  mode,
    input  logic [POS_W-1:0]     pos,
    input  logic                 tag,
    input  logic                 lock,
    input  logic [SA_COUNT-1:0]  sa_mask,
    output logic                 sel
);
    logic [SA_COUNT-1:0] sa_hit;
    logic                t1_hit;

    // One comparator per selectable national bit.
    for (genvar i = 0; i < SA_COUNT; i++) begin : g_sa
        assign sa_hit[i] = sa_mask[i] && (pos == POS_W'(SA_FIRST + i));
    end

    // The T1 data-link bit is the framing bit at position 0.
    always_comb t1_hit = (pos == '0);

    // Combine the mode, the tag and the alignment.
    always_comb begin
        sel = 1'b0;
        if (lock && tag)
            sel = (mode == dlx_pkg::LINE_E1) ? (|sa_hit) : t1_hit;
    end
endmodule

// File: rtl/dlx_byte_pack.sv
// Collects marked bits MSB-first into a byte and pulses ready on every
// eighth. The count clears while alignment is lost.
// Assumes take is high only for marked bits.
module dlx_byte_pack #(
    parameter int unsigned BYTE_W = dlx_pkg::BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              take,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic              rdy_q
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] cnt_q;

    // Shift in marked bits and count them toward a full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            cnt_q  <= '0;
            rdy_q  <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (!lock) begin
                cnt_q <= '0;
            end else if (take) begin
                byte_q <= {byte_q[BYTE_W-2:0], bit_in};
                if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                    rdy_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_RDY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> !rdy_q); // R9
    AST_RDY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> $past(lock)); // R8
endmodule

// File: rtl/dlx_strobe_out.sv
// Registers the serial data and the mark, then forms the strobe:
// a one-period enable, a gated clock high in the low phase, or the raw
// line clock in T1 inverse-mux mode.
// Assumes configuration changes only while the output is not in use.
module dlx_strobe_out (
    input  logic                clk,
    input  logic                rst_n,
    input  dlx_pkg::line_mode_e mode,
    input  logic                imux,
    input  logic                en_mode,
    input  logic                sel,
    input  logic                rx_data,
    output logic                dl_data,
    output logic                mark_q,
    output logic                strobe
);
    logic pass_clk;

    // Register the received bit and its mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_data <= 1'b0;
            mark_q  <= 1'b0;
        end else begin
            dl_data <= rx_data;
            mark_q  <= sel;
        end
    end

    // Inverse-mux pass-through applies to T1 only.
    always_comb pass_clk = imux && (mode == dlx_pkg::LINE_T1);

    // Pick the strobe form; the gated clock rises at the mid-bit falling edge.
    always_comb begin
        if (pass_clk)
            strobe = clk;
        else if (en_mode)
            strobe = mark_q;
        else
            strobe = mark_q && !clk;
    end

    AST_T1_SINGLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == dlx_pkg::LINE_T1 && mark_q) |=> !mark_q); // R3
endmodule

// File: rtl/rx_dlink_extract.sv
// Receive data link extractor top. Passes every received bit to dl_data,
// marks T1 framing data-link bits or selected E1 national bits from the
// framer's alignment, drives the strobe and packs marked bits into bytes.
// Assumes one bit per line_clk and frame alignment from an external framer.
module rx_dlink_extract #(
    parameter int unsigned T1_FRAME = dlx_pkg::T1_BITS,
    parameter int unsigned E1_FRAME = dlx_pkg::E1_BITS,
    parameter int unsigned SA_FIRST = dlx_pkg::SA_LO,
    parameter int unsigned SA_COUNT = dlx_pkg::SA_N,
    parameter int unsigned BYTE_W   = dlx_pkg::BYTE_BITS
) (
    input  logic                line_clk,
    input  logic                rst_n,
    input  logic                rx_data,
    input  logic                frm_sof,
    input  logic                frm_tag,
    input  logic                frm_lock,
    input  logic                cfg_e1,
    input  logic                cfg_strobe_en,
    input  logic                cfg_imux,
    input  logic [SA_COUNT-1:0] cfg_sa_mask,
    output logic                dl_data,
    output logic                dl_strobe,
    output logic [BYTE_W-1:0]   dl_byte,
    output logic                dl_byte_rdy
);
    localparam int unsigned MAX_FRAME = (E1_FRAME > T1_FRAME) ? E1_FRAME : T1_FRAME;
    localparam int unsigned POS_W     = $clog2(MAX_FRAME);

    dlx_pkg::line_mode_e mode;
    logic [POS_W-1:0]    pos;
    logic                tag;
    logic                sel;
    logic                mark;

    // Map the configuration bit to the line mode.
    always_comb mode = cfg_e1 ? dlx_pkg::LINE_E1 : dlx_pkg::LINE_T1;

    dlx_frame_pos #(.T1_FRAME(T1_FRAME), .E1_FRAME(E1_FRAME), .POS_W(POS_W)) u_pos (
        .clk(line_clk), .rst_n(rst_n), .mode(mode), .sof(frm_sof),
        .tag_in(frm_tag), .pos(pos), .tag(tag)
    );

    dlx_bit_select #(.SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT), .POS_W(POS_W)) u_sel (
        .mode(mode), .pos(pos), .tag(tag), .lock(frm_lock),
        .sa_mask(cfg_sa_mask), .sel(sel)
    );

    dlx_strobe_out u_out (
        .clk(line_clk), .rst_n(rst_n), .mode(mode), .imux(cfg_imux),
        .en_mode(cfg_strobe_en), .sel(sel), .rx_data(rx_data),
        .dl_data(dl_data), .mark_q(mark), .strobe(dl_strobe)
    );

    dlx_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk(line_clk), .rst_n(rst_n), .lock(frm_lock), .take(sel),
        .bit_in(rx_data), .byte_q(dl_byte), .rdy_q(dl_byte_rdy)
    );

    AST_RDY_WITH_MARK: assert property (@(posedge line_clk) disable iff (!rst_n)
        dl_byte_rdy |-> mark); // R9
    AST_NO_BYTE_UNLOCKED: assert property (@(posedge line_clk) disable iff (!rst_n)
        !frm_lock |=> !dl_byte_rdy); // R8
endmodule

// File: tb/tb_rx_dlink_extract.sv
module tb_rx_dlink_extract;
    localparam int CLK_PERIOD = 10;

    logic       line_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_data = 1'b0, frm_sof = 1'b0, frm_tag = 1'b0, frm_lock = 1'b0;
    logic       cfg_e1 = 1'b0, cfg_strobe_en = 1'b1, cfg_imux = 1'b0;
    logic [4:0] cfg_sa_mask = '0;
    logic       dl_data, dl_strobe, dl_byte_rdy;
    logic [7:0] dl_byte;

    int total = 0, bad = 0;
    int mpos = 0, mcnt = 0;
    bit mtag = 0;
    logic [7:0]  msh = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  last_rdy_byte = '0;
    int rdy_seen = 0;

    always #(CLK_PERIOD/2) line_clk = ~line_clk;

    rx_dlink_extract dut (
        .line_clk(line_clk), .rst_n(rst_n), .rx_data(rx_data), .frm_sof(frm_sof),
        .frm_tag(frm_tag), .frm_lock(frm_lock), .cfg_e1(cfg_e1),
        .cfg_strobe_en(cfg_strobe_en), .cfg_imux(cfg_imux), .cfg_sa_mask(cfg_sa_mask),
        .dl_data(dl_data), .dl_strobe(dl_strobe), .dl_byte(dl_byte), .dl_byte_rdy(dl_byte_rdy)
    );

    // Stimulus table: {e1, mask[4:0], tag, strobe_en} and marks per frame.
    localparam logic [7:0] VEC [8] = '{
        {1'b0, 5'b00000, 1'b1, 1'b1},
        {1'b0, 5'b00000, 1'b0, 1'b1},
        {1'b1, 5'b11111, 1'b1, 1'b1},
        {1'b1, 5'b00001, 1'b1, 1'b1},
        {1'b1, 5'b10100, 1'b1, 1'b0},
        {1'b1, 5'b11111, 1'b0, 1'b1},
        {1'b1, 5'b01010, 1'b1, 1'b0},
        {1'b0, 5'b00000, 1'b1, 1'b0}
    };
    localparam int VEXP [8] = '{1, 0, 5, 1, 2, 0, 2, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frm_sof = 1'b0; frm_lock = 1'b0; rx_data = 1'b0;
        repeat (3) @(posedge line_clk);
        @(negedge line_clk); #1;
        rst_n = 1'b1;
        mpos = 0; mcnt = 0; mtag = 0; msh = '0;
    endtask

    // One frame (or part), predicting every output from the requirements.
    task automatic run_frame(input int nbits, input bit tag, input bit sof_on, input bit lock,
                             input bit fix_on, input bit fix_bit,
                             output int marks, output int errs);
        int len;
        len = cfg_e1 ? 256 : 193;
        marks = 0; errs = 0;
        for (int i = 0; i < nbits; i++) begin
            bit b, s, exp_mark, exp_rdy, hi, lo;
            b = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = sof_on && (i == 0);
            if (s && fix_on) b = fix_bit;
            if (s) begin mpos = 0; mtag = tag; end
            else mpos = (mpos >= len - 1) ? 0 : mpos + 1;
            exp_mark = lock && mtag &&
                       (cfg_e1 ? (mpos >= 3 && mpos <= 7 && cfg_sa_mask[mpos-3]) : (mpos == 0));
            exp_rdy = 1'b0;
            if (!lock) mcnt = 0;
            else if (exp_mark) begin
                msh = {msh[6:0], b};
                if (mcnt == 7) begin mcnt = 0; exp_rdy = 1'b1; end
                else mcnt++;
            end
            rx_data = b; frm_sof = s; frm_tag = tag; frm_lock = lock;
            @(posedge line_clk); #2;
            hi = dl_strobe;
            @(negedge line_clk); #1;
            lo = dl_strobe;
            if (dl_data !== b) errs++;
            if (cfg_strobe_en) begin
                if (hi !== exp_mark || lo !== exp_mark) errs++;
            end else begin
                if (hi !== 1'b0 || lo !== exp_mark) errs++;
            end
            if (dl_byte_rdy !== exp_rdy || dl_byte !== msh) errs++;
            if (dl_byte_rdy === 1'b1) begin rdy_seen++; last_rdy_byte = dl_byte; end
            if (lo === 1'b1) marks++;
        end
        frm_sof = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int m, e, msum, esum;
        do_reset();
        // R1: reset state
        check(dl_data === 1'b0, "R1 dl_data", int'(dl_data), 0);
        check(dl_strobe === 1'b0, "R1 dl_strobe", int'(dl_strobe), 0);
        check(dl_byte === 8'h00, "R1 dl_byte", int'(dl_byte), 0);
        check(dl_byte_rdy === 1'b0, "R1 dl_byte_rdy", int'(dl_byte_rdy), 0);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 8; v++) begin
            cfg_e1 = VEC[v][7]; cfg_sa_mask = VEC[v][6:2]; cfg_strobe_en = VEC[v][0];
            msum = 0; esum = 0;
            for (int f = 0; f < 3; f++) begin
                run_frame(cfg_e1 ? 256 : 193, VEC[v][1], 1'b1, 1'b1, 1'b0, 1'b0, m, e);
                msum += m; esum += e;
            end
            check(msum == 3 * VEXP[v], cfg_e1 ? "R4 marks per frame" : "R3 marks per frame",
                  msum, 3 * VEXP[v]);
            check(esum == 0, "R2 R5 R6 R9 bitwise outputs", esum, 0);
        end

        // R7: T1 inverse-mux passes the line clock
        frm_lock = 1'b0; cfg_e1 = 1'b0; cfg_imux = 1'b1;
        e = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge line_clk); #2;
            if (dl_strobe !== 1'b1) e++;
            @(negedge line_clk); #1;
            if (dl_strobe !== 1'b0) e++;
        end
        check(e == 0, "R7 T1 inverse-mux clock", e, 0);
        mcnt = 0;

        // R7: inverse-mux has no effect in E1
        cfg_e1 = 1'b1; cfg_sa_mask = 5'b00000; cfg_strobe_en = 1'b1;
        run_frame(256, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, m, e);
        check(m == 0 && e == 0, "R7 E1 ignores inverse-mux", m + e, 0);
        cfg_imux = 1'b0;

        // R8: loss of lock mid-byte
        do_reset();
        cfg_e1 = 1'b1; cfg_sa_mask = 5'b00111;
        run_frame(256, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, m, e);
        check(m == 3 && e == 0, "R8 partial byte before unlock", m * 10 + e, 30);
        run_frame(256, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, m, e);
        check(m == 0 && e == 0, "R8 no marks while unlocked", m * 10 + e, 0);
        rdy_seen = 0; esum = 0;
        for (int f = 0; f < 3; f++) begin
            run_frame(256, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, m, e);
            esum += e;
        end
        check(esum == 0 && rdy_seen == 1, "R8 recount after relock", rdy_seen, 1);

        // R10: free-running position without frame pulses
        cfg_e1 = 1'b0; cfg_strobe_en = 1'b1;
        run_frame(193, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, m, e);
        msum = m; esum = e;
        for (int f = 0; f < 2; f++) begin
            run_frame(193, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, m, e);
            check(m == 1, "R10 wrap marks framing bit", m, 1);
            esum += e;
        end
        check(esum == 0, "R10 wrap bitwise outputs", esum, 0);

        // R9: MSB-first byte from T1 framing bits 1010_0101
        do_reset();
        cfg_e1 = 1'b0; rdy_seen = 0;
        for (int f = 0; f < 8; f++) begin
            logic [7:0] pat;
            pat = 8'hA5;
            run_frame(193, 1'b1, 1'b1, 1'b1, 1'b1, pat[7-f], m, e);
        end
        check(rdy_seen == 1 && last_rdy_byte == 8'hA5, "R9 MSB-first byte",
              int'(last_rdy_byte), 8'hA5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule